// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in an HDLC receive path behind flag detection and zero-bit removal. Its input is a stream of bytes, each with a valid strobe. Start-of-frame and end-of-frame markers ride on the first and last byte of each frame. The block looks at the first one or two bytes of every frame, which hold the destination address. It compares them with a programmed station address and a programmed broadcast address, and it uses a 4-bit enable field to choose which bytes of which address take part.

A frame whose address is accepted is forwarded whole to the downstream buffer interface. The address bytes are included, the order is kept, and the markers are kept. A frame that is not accepted produces no output at all. The first bytes of every frame are held in a small queue that can be committed or rewound while the decision is still open. This lets frames arrive back to back, with no idle cycles between them, without losing a byte. For every frame the block raises a one-cycle status pulse that reports whether the frame was accepted or dropped.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, out_valid_o, frame_ok_o and frame_drop_o are all 0 until a frame is accepted or ends.
- R2: When match_en_i is 0000 the filter is open: every frame is forwarded in full, including a one-byte frame.
- R3: match_en_i bit 0 compares the first frame byte with station_addr_i[7:0], and bit 1 compares the second frame byte with station_addr_i[15:8]. The station target matches only if at least one of these bits is set and every enabled byte is equal.
- R4: match_en_i bit 2 compares the first frame byte with bcast_addr_i[7:0], and bit 3 compares the second frame byte with bcast_addr_i[15:8]. The same all-enabled-bytes rule decides the broadcast target.
- R5: A frame is accepted if the station target or the broadcast target matches. Otherwise none of its bytes appears at the output.
- R6: A frame that ends before an enabled address byte has arrived (a one-byte frame while bit 1 or bit 3 is set) is dropped.
- R7: An accepted frame comes out byte for byte and in order. out_sof_o is set on its first byte and out_eof_o on its last byte. Idle gaps between input bytes are allowed.
- R8: The cycle after each end-of-frame input byte carries exactly one of frame_ok_o (accepted) or frame_drop_o (dropped), each for one cycle.
- R9: Frames may follow each other with no idle cycles between them, and every accepted frame is still forwarded completely.
- R10: The holding queue never receives a write while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | Input byte is the first byte of a frame |
| in_eof_i | input | 1 | Input byte is the last byte of a frame |
| match_en_i | input | 4 | Compare enables: bit0/bit1 station bytes 1/2, bit2/bit3 broadcast bytes 1/2 |
| station_addr_i | input | 16 | Station address, first byte in [7:0] |
| bcast_addr_i | input | 16 | Broadcast address, first byte in [7:0] |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | Output byte starts a frame |
| out_eof_o | output | 1 | Output byte ends a frame |
| frame_ok_o | output | 1 | One-cycle pulse: frame accepted |
| frame_drop_o | output | 1 | One-cycle pulse: frame dropped |

## Verification
A wrong commit or rewind pointer in the holding queue shows up at the output within two or three cycles of the deciding byte. It appears as a duplicated byte, a missing address byte, or bytes from a rejected frame leaking out. A stuck frame state shows up on the next end-of-frame byte, as a wrong or missing status pulse, and from then on in the forwarded stream. Back-to-back frames and one-byte frames are where a pointer or state error is most likely to stay hidden, so the stimulus covers both along with idle gaps inside a frame.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } af_beat_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_ACC,
    ST_REJ
  } af_state_e;
endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
  import hdlc_af_pkg::*;
(
  input  logic [3:0]          en_i,
  input  logic [2*BYTE_W-1:0] sta_i,
  input  logic [2*BYTE_W-1:0] bc_i,
  input  logic [BYTE_W-1:0]   byte0_i,
  input  logic [BYTE_W-1:0]   byte1_i,
  input  logic                have1_i,
  output logic                accept_o
);
  logic sta_on, bc_on, sta_ok, bc_ok, short_frame;

  always_comb begin
    sta_on      = en_i[0] | en_i[1];
    bc_on       = en_i[2] | en_i[3];
    sta_ok      = (!en_i[0] || byte0_i == sta_i[BYTE_W-1:0]) &&
                  (!en_i[1] || (have1_i && byte1_i == sta_i[2*BYTE_W-1:BYTE_W]));
    bc_ok       = (!en_i[2] || byte0_i == bc_i[BYTE_W-1:0]) &&
                  (!en_i[3] || (have1_i && byte1_i == bc_i[2*BYTE_W-1:BYTE_W]));
    short_frame = (en_i[1] | en_i[3]) & ~have1_i;
    accept_o    = !short_frame &&
                  ((en_i == 4'b0000) || (sta_on && sta_ok) || (bc_on && bc_ok));
  end
endmodule

// File: rtl/hdlc_af_fifo.sv
module hdlc_af_fifo
  import hdlc_af_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  af_beat_t beat_i,
  input  logic     commit_i,
  input  logic     rewind_i,
  output logic     valid_o,
  output af_beat_t beat_o,
  output logic     full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned PW = AW + 1;

  af_beat_t mem_q [DEPTH];
  logic [PW-1:0] wr_q, cmt_q, rd_q, wr_inc;
  logic store;

  assign store   = push_i & ~rewind_i;
  assign wr_inc  = wr_q + PW'(1);
  assign valid_o = (rd_q != cmt_q);
  assign beat_o  = mem_q[rd_q[AW-1:0]];
  assign full_o  = ((wr_q - rd_q) == PW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (store) mem_q[wr_q[AW-1:0]] <= beat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (rewind_i)   wr_q <= cmt_q;
      else if (store) wr_q <= wr_inc;
      if (commit_i)   cmt_q <= store ? wr_inc : wr_q;
      if (valid_o)    rd_q <= rd_q + PW'(1);
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int unsigned HOLD_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic [3:0]        match_en_i,
  input  logic [15:0]       station_addr_i,
  input  logic [15:0]       bcast_addr_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output logic              frame_ok_o,
  output logic              frame_drop_o
);
  af_state_e state_q, state_d;
  logic [BYTE_W-1:0] b0_q;
  logic need2, decide_now, accept, frame_open;
  logic push, commit, rewind, fifo_push, fifo_full, out_vld;
  logic eof_evt, ok_d;
  af_beat_t in_beat, out_beat;

  assign need2      = match_en_i[1] | match_en_i[3];
  assign frame_open = (state_q != ST_IDLE);
  // byte0 decides alone when no second byte is compared or the frame ends there
  assign decide_now = in_sof_i ? (in_eof_i | ~need2) : (state_q == ST_PEND);

  hdlc_af_match u_match (
    .en_i    (match_en_i),
    .sta_i   (station_addr_i),
    .bc_i    (bcast_addr_i),
    .byte0_i (in_sof_i ? in_data_i : b0_q),
    .byte1_i (in_data_i),
    .have1_i (~in_sof_i),
    .accept_o(accept)
  );

  always_comb begin
    push    = in_valid_i & (in_sof_i | state_q == ST_PEND | state_q == ST_ACC);
    commit  = in_valid_i & ((decide_now & accept) | (~in_sof_i & state_q == ST_ACC));
    rewind  = in_valid_i & decide_now & ~accept;
    eof_evt = in_valid_i & in_eof_i & (in_sof_i | frame_open);
    ok_d    = decide_now ? accept : (state_q == ST_ACC);
    state_d = state_q;
    if (in_valid_i && (in_sof_i || frame_open)) begin
      if (in_eof_i)        state_d = ST_IDLE;
      else if (decide_now) state_d = accept ? ST_ACC : ST_REJ;
      else if (in_sof_i)   state_d = ST_PEND;
    end
  end

  assign fifo_push = push & ~rewind;
  assign in_beat   = '{sof: in_sof_i, eof: in_eof_i, data: in_data_i};

  hdlc_af_fifo #(.DEPTH(HOLD_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .beat_i  (in_beat),
    .commit_i(commit),
    .rewind_i(rewind),
    .valid_o (out_vld),
    .beat_o  (out_beat),
    .full_o  (fifo_full)
  );

  assign out_valid_o = out_vld;
  assign out_data_o  = out_beat.data;
  assign out_sof_o   = out_vld & out_beat.sof;
  assign out_eof_o   = out_vld & out_beat.eof;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      b0_q         <= '0;
      frame_ok_o   <= 1'b0;
      frame_drop_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      if (in_valid_i && in_sof_i) b0_q <= in_data_i;
      frame_ok_o   <= eof_evt & ok_d;
      frame_drop_o <= eof_evt & ~ok_d;
    end
  end
endmodule

// File: rtl/hdlc_af_checker.sv
module hdlc_af_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_sof_i,
  input logic       in_eof_i,
  input logic [3:0] match_en_i,
  input logic       frame_ok_o,
  input logic       frame_drop_o,
  input logic       frame_open,
  input logic       fifo_push,
  input logic       fifo_full
);
  assert_status_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_ok_o && frame_drop_o));

  assert_status_after_eof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_o || frame_drop_o) |-> $past(in_valid_i && in_eof_i && (in_sof_i || frame_open)));

  assert_eof_gives_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_eof_i && (in_sof_i || frame_open)) |=> (frame_ok_o || frame_drop_o));

  assert_open_filter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && in_eof_i && match_en_i == 4'b0000) |=> frame_ok_o);

  assert_short_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && in_eof_i && (match_en_i[1] || match_en_i[3])) |=> frame_drop_o);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push |-> !fifo_full);
endmodule

bind hdlc_addr_filter hdlc_af_checker u_chk (.*);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] en = '0;
  logic [15:0] sta = 16'hB2A1, bc = 16'hD4C3;
  logic out_valid, out_sof, out_eof, f_ok, f_drop;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [9:0] got_q[$], exp_q[$];
  logic st_got[$], st_exp[$];

  always #10 clk = ~clk;

  hdlc_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .match_en_i(en),
    .station_addr_i(sta), .bcast_addr_i(bc),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sof_o(out_sof),
    .out_eof_o(out_eof), .frame_ok_o(f_ok), .frame_drop_o(f_drop));

  // fields: en[24:21] len[20:17] b0[16:9] b1[8:1] accept[0]
  localparam logic [24:0] VEC [16] = '{
    {4'b0000, 4'd5, 8'h12, 8'h34, 1'b1},  // R2
    {4'b0001, 4'd4, 8'hA1, 8'h55, 1'b1},  // R3
    {4'b0001, 4'd4, 8'hA2, 8'h55, 1'b0},  // R3
    {4'b0011, 4'd4, 8'hA1, 8'hB2, 1'b1},  // R3
    {4'b0011, 4'd4, 8'hA1, 8'hB3, 1'b0},  // R3
    {4'b0010, 4'd3, 8'h00, 8'hB2, 1'b1},  // R3
    {4'b0100, 4'd4, 8'hC3, 8'h00, 1'b1},  // R4
    {4'b1100, 4'd4, 8'hC3, 8'hD4, 1'b1},  // R4
    {4'b1100, 4'd4, 8'hC3, 8'hD5, 1'b0},  // R4
    {4'b1111, 4'd4, 8'hC3, 8'hD4, 1'b1},  // R5
    {4'b1111, 4'd4, 8'hA1, 8'hB2, 1'b1},  // R5
    {4'b1111, 4'd4, 8'hA1, 8'hD4, 1'b0},  // R5
    {4'b0011, 4'd1, 8'hA1, 8'h00, 1'b0},  // R6
    {4'b0001, 4'd1, 8'hA1, 8'h00, 1'b1},  // R6
    {4'b0000, 4'd1, 8'h77, 8'h00, 1'b1},  // R2
    {4'b0010, 4'd2, 8'h00, 8'hB2, 1'b1}   // R3
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) got_q.push_back({out_sof, out_eof, out_data});
    if (f_ok || f_drop) st_got.push_back(f_ok);
  end

  function automatic logic [7:0] pbyte(input logic [24:0] v, input int i, input int seed);
    if (i == 0) return v[16:9];
    if (i == 1) return v[8:1];
    return 8'(seed * 16 + i);
  endfunction

  task automatic send(input logic [24:0] v, input int seed, input int gap);
    int len = int'(v[20:17]);
    for (int i = 0; i < len; i++) begin
      if (i > 0) repeat (gap) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; en = v[24:21];
      in_data = pbyte(v, i, seed);
      in_sof = (i == 0); in_eof = (i == len - 1);
      if (v[0]) exp_q.push_back({in_sof, in_eof, in_data});
      @(negedge clk);
    end
    st_exp.push_back(v[0]);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {req, " byte"}, int'(got_q[i]), int'(exp_q[i]));
    check(st_got == st_exp, {req, " status"}, st_got.size(), st_exp.size());
    got_q.delete(); exp_q.delete(); st_got.delete(); st_exp.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid && !f_ok && !f_drop, "R1", {out_valid, f_ok, f_drop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !f_ok && !f_drop, "R1", {out_valid, f_ok, f_drop}, 0);

    // table walk, R2..R7, gaps alternate
    for (int k = 0; k < 16; k++) begin
      send(VEC[k], k + 1, k % 3);
      idle(6);
      compare($sformatf("R5 R7 vec%0d", k));
    end

    // R8: pulse timing on a one-byte accepted frame
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; en = 4'b0000; in_data = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    check(f_ok && !f_drop, "R8 pulse", {f_ok, f_drop}, 2);
    @(negedge clk);
    check(!f_ok && !f_drop, "R8 one cycle", {f_ok, f_drop}, 0);
    idle(4);
    got_q.delete(); st_got.delete();

    // R8: drop pulse timing on a mismatching frame
    send(VEC[2], 3, 0);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    check(f_drop && !f_ok, "R8 drop pulse", {f_ok, f_drop}, 1);
    idle(5);
    compare("R8 drop frame");

    // R9 R10: back-to-back frames, no idle cycles
    send(VEC[3], 20, 0); send(VEC[2], 21, 0); send(VEC[12], 22, 0);
    send(VEC[14], 23, 0); send(VEC[0], 24, 0); send(VEC[11], 25, 0);
    send(VEC[13], 26, 0); send(VEC[10], 27, 0);
    idle(8);
    compare("R9 back-to-back");

    // R7: long accepted frame with mixed gaps
    send({4'b0011, 4'd15, 8'hA1, 8'hB2, 1'b1}, 9, 1);
    idle(6);
    compare("R7 long frame");
    finish_up();
  end
endmodule